// File: doc/BRIEF.md
# Timer Count-Enable Edge Selector

This block decides, once per system-clock cycle, whether a timer channel's counter should advance. Each channel owns an 8-bit control word that picks a counting source (the undivided system clock, one of three prescaled clock levels, an external clock pin, or a cascade pulse from a neighbouring channel) and which transitions of that source are counted. The same word also carries a 3-bit counter-clear selector, which is passed straight out to the clear logic elsewhere.

The block turns the chosen source into a registered, one-cycle count-enable pulse. A small per-channel counter sits behind each enable to show the behaviour. Sources that are levels are sampled in the system-clock domain and compared with the value from the previous cycle; the external pin is first passed through a two-flop synchronizer. The control word is locked while the channel runs. A write attempted during a run is dropped and raises a sticky flag. The channel count is a parameter, with three channels by default, and each channel is configured on its own.

Top module: `tes_top`

## Requirements
- R1: After reset every control word is 0, and every count enable, clear select, write-error flag and counter output is 0.
- R2: Control word layout: bits 7:5 are the clear-source selector and appear on the channel's `clr_sel_o` slice one cycle after an accepted write; bits 4:3 are the edge mode; bits 2:0 are the source code (000 undivided, 001 divide-by-4, 010 divide-by-16, 011 divide-by-64, 100 external, 111 cascade).
- R3: With source 000, the count enable is high in every cycle that follows a running cycle, whatever the edge mode.
- R4: For sources 001 to 100, edge mode 00 gives one enable per low-to-high change of the sampled source, and edge mode 01 gives one enable per high-to-low change.
- R5: Edge mode 10 or 11 counts both changes of the source. Over any 128 cycles, the divide-by-4 source then gives 64 enables, against 32 with rising-edge counting.
- R6: The external pin passes through two synchronizer flops before edge detection, so an external change is seen two cycles later than a prescaler change.
- R7: With source 111, each cycle in which the cascade input is high gives exactly one enable, and the edge mode has no effect.
- R8: While the channel's phase-mode input is high, no count enable is produced, whatever the edge mode or source.
- R9: Source codes 101 and 110 produce no count enable.
- R10: The enable is registered: it is high only in the cycle after a cycle in which the run bit was 1 and a count event occurred. The demonstration counter adds one for each enable cycle.
- R11: A write while the run bit is 1 is ignored, so clear select and counting stay unchanged. It sets the channel's write-error flag, which stays set until reset.
- R12: Channels are independent: each has its own control word, run bit, phase input, cascade input and counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | NCH | Per-channel run bit |
| wr_en_i | input | NCH | Per-channel control-word write strobe |
| wr_data_i | input | 8 | Control word write data (shared) |
| pre4_i | input | 1 | Divide-by-4 prescaler level |
| pre16_i | input | 1 | Divide-by-16 prescaler level |
| pre64_i | input | 1 | Divide-by-64 prescaler level |
| ext_clk_i | input | 1 | Asynchronous external clock pin |
| casc_i | input | NCH | Per-channel cascade overflow/underflow pulse |
| phase_i | input | NCH | Per-channel phase-counting mode active |
| cnt_en_o | output | NCH | Registered count-enable pulse |
| clr_sel_o | output | 3*NCH | Clear-source selector per channel |
| wr_err_o | output | NCH | Sticky write-while-running flag |
| count_o | output | CNT_W*NCH | Demonstration counter per channel |

## Verification
Every source code is paired with every edge mode under free-running prescalers, a randomly toggling external pin and random cascade pulses. The enable count of each pairing is compared with a reference model. This separates rising, falling and both-edge counting, and the pairings with invalid codes show that those codes stay silent. Fixed 128-cycle windows on the divide-by-4 source pin down the exact 32 and 64 counts. A run on the undivided clock checks that one enable arrives per cycle. Random runs on two channels at once, with phase mode asserted in some of them, show that the channels do not disturb each other and that phase mode suppresses counting. Writes issued while a channel runs check that the clear select stays unchanged and that the error flag latches.

// File: rtl/tes_pkg.sv
package tes_pkg;
  localparam int CTRL_W = 8;

  localparam logic [2:0] SRC_UNDIV = 3'b000;
  localparam logic [2:0] SRC_DIV4  = 3'b001;
  localparam logic [2:0] SRC_DIV16 = 3'b010;
  localparam logic [2:0] SRC_DIV64 = 3'b011;
  localparam logic [2:0] SRC_EXT   = 3'b100;
  localparam logic [2:0] SRC_CASC  = 3'b111;

  typedef struct packed {
    logic [2:0] clr;
    logic [1:0] edg;
    logic [2:0] src;
  } ctrl_t;

  // Event detector for a sampled level: mode 1x = any change, 01 = fall, 00 = rise
  function automatic logic edge_hit(input logic cur, input logic prev, input logic [1:0] mode);
    if (mode[1])      return cur ^ prev;
    else if (mode[0]) return prev & ~cur;
    else              return cur & ~prev;
  endfunction
endpackage

// File: rtl/tes_sync.sv
module tes_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/tes_ctrl_reg.sv
module tes_ctrl_reg
  import tes_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output ctrl_t             ctrl_o,
  output logic              err_o
);
  ctrl_t ctrl_q;
  logic  err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      err_q  <= 1'b0;
    end else if (wr_en_i) begin
      if (run_i) err_q  <= 1'b1;
      else       ctrl_q <= ctrl_t'(wr_data_i);
    end
  end

  assign ctrl_o = ctrl_q;
  assign err_o  = err_q;
endmodule

// File: rtl/tes_edge_det.sv
module tes_edge_det
  import tes_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run_i,
  input  logic       phase_i,
  input  logic [2:0] src_i,
  input  logic [1:0] edg_i,
  input  logic       pre4_i,
  input  logic       pre16_i,
  input  logic       pre64_i,
  input  logic       ext_i,
  input  logic       casc_i,
  output logic       cnt_en_o
);
  logic lvl;
  logic lvl_q;
  logic hit;
  logic en_q;

  always_comb begin
    case (src_i)
      SRC_DIV4:  lvl = pre4_i;
      SRC_DIV16: lvl = pre16_i;
      SRC_DIV64: lvl = pre64_i;
      SRC_EXT:   lvl = ext_i;
      default:   lvl = 1'b0;
    endcase
  end

  always_comb begin
    case (src_i)
      SRC_UNDIV:                               hit = 1'b1;
      SRC_DIV4, SRC_DIV16, SRC_DIV64, SRC_EXT: hit = edge_hit(lvl, lvl_q, edg_i);
      SRC_CASC:                                hit = casc_i;
      default:                                 hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      lvl_q <= lvl;
      en_q  <= run_i & ~phase_i & hit;
    end
  end

  assign cnt_en_o = en_q;
endmodule

// File: rtl/tes_top.sv
module tes_top
  import tes_pkg::*;
#(
  parameter int NCH         = 3,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCH-1:0]       run_i,
  input  logic [NCH-1:0]       wr_en_i,
  input  logic [CTRL_W-1:0]    wr_data_i,
  input  logic                 pre4_i,
  input  logic                 pre16_i,
  input  logic                 pre64_i,
  input  logic                 ext_clk_i,
  input  logic [NCH-1:0]       casc_i,
  input  logic [NCH-1:0]       phase_i,
  output logic [NCH-1:0]       cnt_en_o,
  output logic [3*NCH-1:0]     clr_sel_o,
  output logic [NCH-1:0]       wr_err_o,
  output logic [CNT_W*NCH-1:0] count_o
);
  logic           ext_s;
  logic [3*NCH-1:0] src_sel;

  tes_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (ext_clk_i),
    .q_o (ext_s)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ctrl_t            ctrl;
    logic             en;
    logic [CNT_W-1:0] cnt_q;

    tes_ctrl_reg u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .run_i     (run_i[c]),
      .wr_en_i   (wr_en_i[c]),
      .wr_data_i (wr_data_i),
      .ctrl_o    (ctrl),
      .err_o     (wr_err_o[c])
    );

    tes_edge_det u_det (
      .clk      (clk),
      .rst      (rst),
      .run_i    (run_i[c]),
      .phase_i  (phase_i[c]),
      .src_i    (ctrl.src),
      .edg_i    (ctrl.edg),
      .pre4_i   (pre4_i),
      .pre16_i  (pre16_i),
      .pre64_i  (pre64_i),
      .ext_i    (ext_s),
      .casc_i   (casc_i[c]),
      .cnt_en_o (en)
    );

    always_ff @(posedge clk) begin
      if (rst)     cnt_q <= '0;
      else if (en) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_en_o[c]                 = en;
    assign clr_sel_o[3*c +: 3]         = ctrl.clr;
    assign src_sel[3*c +: 3]           = ctrl.src;
    assign count_o[CNT_W*c +: CNT_W]   = cnt_q;
  end
endmodule

// File: rtl/tes_chk.sv
module tes_chk #(
  parameter int NCH   = 3,
  parameter int CNT_W = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NCH-1:0]       run_i,
  input logic [NCH-1:0]       wr_en_i,
  input logic [NCH-1:0]       phase_i,
  input logic [NCH-1:0]       casc_i,
  input logic [3*NCH-1:0]     src_sel,
  input logic [NCH-1:0]       cnt_en_o,
  input logic [3*NCH-1:0]     clr_sel_o,
  input logic [NCH-1:0]       wr_err_o,
  input logic [CNT_W*NCH-1:0] count_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !run_i[c] |=> !cnt_en_o[c]);
    // R8
    phase_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      phase_i[c] |=> !cnt_en_o[c]);
    // R3
    undiv_every_chk: assert property (@(posedge clk) disable iff (rst)
      (run_i[c] && !phase_i[c] && src_sel[3*c +: 3] == 3'b000) |=> cnt_en_o[c]);
    // R7
    casc_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (run_i[c] && !phase_i[c] && src_sel[3*c +: 3] == 3'b111) |=> (cnt_en_o[c] == $past(casc_i[c])));
    // R9
    bad_code_chk: assert property (@(posedge clk) disable iff (rst)
      (src_sel[3*c +: 3] == 3'b101 || src_sel[3*c +: 3] == 3'b110) |=> !cnt_en_o[c]);
    // R11
    locked_write_chk: assert property (@(posedge clk) disable iff (rst)
      (run_i[c] && wr_en_i[c]) |=> ($stable(clr_sel_o[3*c +: 3]) && wr_err_o[c]));
    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      wr_err_o[c] |=> wr_err_o[c]);
    // R10
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
      cnt_en_o[c] |=> (count_o[CNT_W*c +: CNT_W] == $past(count_o[CNT_W*c +: CNT_W]) + 1'b1));
  end
endmodule

bind tes_top tes_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_tes_chk (
  .clk       (clk),
  .rst       (rst),
  .run_i     (run_i),
  .wr_en_i   (wr_en_i),
  .phase_i   (phase_i),
  .casc_i    (casc_i),
  .src_sel   (src_sel),
  .cnt_en_o  (cnt_en_o),
  .clr_sel_o (clr_sel_o),
  .wr_err_o  (wr_err_o),
  .count_o   (count_o)
);

// File: tb/tb_tes_top.sv
module tb_tes_top;
  localparam int NCH   = 3;
  localparam int CNT_W = 16;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [NCH-1:0]       run_i = '0;
  logic [NCH-1:0]       wr_en_i = '0;
  logic [7:0]           wr_data_i = '0;
  logic                 pre4_i, pre16_i, pre64_i;
  logic                 ext_clk_i = 1'b0;
  logic [NCH-1:0]       casc_i = '0;
  logic [NCH-1:0]       phase_i = '0;
  logic [NCH-1:0]       cnt_en_o;
  logic [3*NCH-1:0]     clr_sel_o;
  logic [NCH-1:0]       wr_err_o;
  logic [CNT_W*NCH-1:0] count_o;

  tes_top #(.NCH(NCH), .CNT_W(CNT_W)) dut (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;
  logic [7:0] divc = '0;
  assign pre4_i  = divc[1];
  assign pre16_i = divc[3];
  assign pre64_i = divc[5];

  // free-running prescalers and random ext / cascade, driven away from the edge
  always @(negedge clk) begin
    divc <= divc + 1'b1;
    if (($urandom % 5) == 0) ext_clk_i <= ~ext_clk_i;
    for (int c = 0; c < NCH; c++) casc_i[c] <= (($urandom % 4) == 0);
  end

  // reference model built from the requirements
  logic [7:0]  m_ctrl [NCH];
  logic        m_prev [NCH];
  logic        m_s1, m_s2;
  int unsigned m_cnt  [NCH];

  function automatic logic ev(input logic [7:0] cw, input logic prev, output logic lvl,
                              input logic s2, input logic casc);
    logic [2:0] s;
    logic [1:0] m;
    s = cw[2:0]; m = cw[4:3];
    case (s)
      3'b001: lvl = pre4_i;
      3'b010: lvl = pre16_i;
      3'b011: lvl = pre64_i;
      3'b100: lvl = s2;
      default: lvl = 1'b0;
    endcase
    case (s)
      3'b000: return 1'b1;
      3'b001, 3'b010, 3'b011, 3'b100:
        return m[1] ? (lvl ^ prev) : (m[0] ? (prev & ~lvl) : (lvl & ~prev));
      3'b111: return casc;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin m_ctrl[c] = '0; m_prev[c] = 0; m_cnt[c] = 0; end
      m_s1 = 0; m_s2 = 0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        logic l, e;
        e = ev(m_ctrl[c], m_prev[c], l, m_s2, casc_i[c]);
        if (run_i[c] && !phase_i[c] && e) m_cnt[c]++;
        m_prev[c] = l;
        if (wr_en_i[c] && !run_i[c]) m_ctrl[c] = wr_data_i;
      end
      m_s2 = m_s1;
      m_s1 = ext_clk_i;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int c, input logic [7:0] d);
    @(negedge clk); wr_en_i[c] = 1'b1; wr_data_i = d;
    @(negedge clk); wr_en_i[c] = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic window(input logic [NCH-1:0] mask, input int n);
    @(negedge clk); run_i = mask;
    repeat (n) @(negedge clk);
    run_i = '0;
    repeat (3) @(negedge clk);
  endtask

  function automatic int cnt(input int c);
    return int'(count_o[CNT_W*c +: CNT_W]);
  endfunction

  task automatic cmp(input int c, input string req);
    chk(cnt(c) == int'(m_cnt[c] % (1 << CNT_W)), req, cnt(c), m_cnt[c] % (1 << CNT_W));
  endtask

  initial begin
    while (cycles < 150000 && !done) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int base, v;
    void'($urandom(32'h5eed_0123));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cnt_en_o == '0, "R1 cnt_en", cnt_en_o, 0);
    chk(clr_sel_o == '0, "R1 clr_sel", clr_sel_o, 0);
    chk(wr_err_o == '0, "R1 wr_err", wr_err_o, 0);
    chk(count_o == '0, "R1 count", count_o, 0);

    // R2 field layout
    wr(0, 8'hA9);
    chk(clr_sel_o[2:0] == 3'b101, "R2 clr field", clr_sel_o[2:0], 5);

    // R3 undivided clock ignores edge field
    wr(0, 8'h18);
    base = cnt(0);
    window(3'b001, 50);
    chk(cnt(0) - base == 50, "R3 undivided", cnt(0) - base, 50);
    cmp(0, "R3 model");

    // R5 anchors: /4 rising 32, both 64 per 128 cycles
    wr(0, 8'h01);
    base = cnt(0); window(3'b001, 128);
    chk(cnt(0) - base == 32, "R4 div4 rising", cnt(0) - base, 32);
    wr(0, 8'h11);
    base = cnt(0); window(3'b001, 128);
    chk(cnt(0) - base == 64, "R5 div4 both", cnt(0) - base, 64);

    // R4 R5 R6 R7 R9 every source/edge pairing vs model
    for (int s = 0; s < 8; s++) begin
      for (int m = 0; m < 4; m++) begin
        wr(0, {3'b000, m[1:0], s[2:0]});
        window(3'b001, 96);
        case (s)
          4: cmp(0, "R6 external");
          5, 6: cmp(0, "R9 invalid code");
          7: cmp(0, "R7 cascade");
          default: cmp(0, m[1] ? "R5 both edges" : "R4 single edge");
        endcase
      end
    end

    // R8 phase mode suppresses counting
    wr(0, 8'h11);
    phase_i[0] = 1'b1;
    base = cnt(0); window(3'b001, 64);
    chk(cnt(0) == base, "R8 phase mode", cnt(0) - base, 0);
    phase_i[0] = 1'b0;

    // R11 write while running is ignored and latches error
    wr(0, 8'h40);
    @(negedge clk); run_i[0] = 1'b1;
    @(negedge clk); wr_en_i[0] = 1'b1; wr_data_i = 8'hE7;
    @(negedge clk); wr_en_i[0] = 1'b0;
    @(negedge clk);
    chk(clr_sel_o[2:0] == 3'b010, "R11 clr unchanged", clr_sel_o[2:0], 2);
    chk(wr_err_o[0] == 1'b1, "R11 err set", wr_err_o[0], 1);
    run_i[0] = 1'b0;
    repeat (3) @(negedge clk);
    cmp(0, "R11 src unchanged");
    wr(0, 8'h20);
    chk(clr_sel_o[2:0] == 3'b001, "R11 later write", clr_sel_o[2:0], 1);
    chk(wr_err_o[0] == 1'b1, "R11 sticky", wr_err_o[0], 1);

    // R10 R12 random configs on two channels with phase toggling
    for (int i = 0; i < 40; i++) begin
      wr(0, 8'($urandom));
      wr(1, 8'($urandom));
      phase_i[1:0] = (($urandom % 4) == 0) ? 2'($urandom) : 2'b00;
      v = 20 + ($urandom % 80);
      window(($urandom % 2) ? 3'b011 : 3'b010, v);
      phase_i = '0;
      cmp(0, "R12 channel 0");
      cmp(1, "R12 channel 1");
    end
    chk(cnt(2) == 0, "R10 idle channel", cnt(2), 0);
    chk(wr_err_o[1] == 1'b0, "R12 err independent", wr_err_o[1], 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule